// File: doc/BRIEF.md
# Receive Frame Length Filter

This block sits behind a receive engine that fills buffers in a descriptor ring. It walks the filled buffers in ring order, one per clock, for as long as its own consumer index trails the engine's current descriptor index. The first two bytes of each buffer hold the length the engine wrote, with the low byte first. A header region of configurable size comes next, and the payload follows it. The block reads those two bytes through a combinational lookup port addressed by its consumer index.

A frame that fits in a buffer goes downstream with its true length, which is the header offset plus the parsed length. A frame longer than the usable space counts as a giant. The block releases its buffer and adds one to a giant counter. It then loads a skip byte count equal to the overflow. Each following buffer is released without parsing, and each one takes one full buffer size off the count, which stops at zero. The continuation buffers of an oversized frame therefore never reach the parser.

Top module: `rxlen_filter`

## Requirements
- R1: A buffer is consumed only in a cycle where `consIdx` differs from `curIdx`. At most one buffer is consumed per clock. `consIdx` then advances by one modulo DEPTH, and DEPTH is a power of two.
- R2: The length is `bufHead[7:0]` as the low byte and `bufHead[15:8]` as the high byte, both taken from the buffer at `consIdx`.
- R3: Usable space is `cfgBufSize - cfgRxOffset`, and the configuration must keep `cfgRxOffset <= cfgBufSize`. A length at or below the usable space gives a one-cycle `frmValid` on the clock after consumption. The same clock sets `frmIdx` to the buffer index and `frmLen` to `cfgRxOffset` plus the length.
- R4: When no skip is pending, a length above the usable space releases that buffer (`relValid`, `relIdx`) on the clock after consumption and increments `giantCount` by one.
- R5: An oversized frame sets the skip count to its length minus the usable space. While the skip count is nonzero, each consumed buffer is released unparsed and its header is ignored: no frame, no giant. The skip count drops by `cfgBufSize` and saturates at zero.
- R6: Releases and frames leave in consumption order, and `frmValid` and `relValid` are never high together.
- R7: After reset, `consIdx` is 0, `giantCount` is 0, no skip is pending, and both valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBufSize | input | LEN_W | Buffer capacity in bytes |
| cfgRxOffset | input | LEN_W | Header offset in front of the payload |
| curIdx | input | IDX_W | Engine's current descriptor index |
| bufHead | input | 16 | First two bytes of buffer `consIdx`, byte 0 in bits 7:0 |
| consIdx | output | IDX_W | Consumer index, also the lookup address |
| frmValid | output | 1 | Good frame pulse |
| frmIdx | output | IDX_W | Ring index of the good frame |
| frmLen | output | LEN_W+1 | Offset plus parsed length |
| relValid | output | 1 | Dropped buffer release pulse |
| relIdx | output | IDX_W | Ring index of the released buffer |
| giantCount | output | CNT_W | Oversized frames seen, wrapping |

## Verification
The consumer index can wrap to slot zero in the same cycle that a giant is detected or a continuation buffer is skipped. The bench provokes this by posting a long oversized frame whose continuation run crosses the ring end several times, and by placing giants at arbitrary slots. A scoreboard built from the length rules predicts each release and each frame with its index and giant count. The clock where the skip count reaches zero is also covered: the next buffer must be parsed fresh, and a second giant placed there must be counted.

// File: rtl/rxlen_pkg.sv
package rxlen_pkg;
  localparam int HDR_W = 16;

  typedef struct packed {
    logic consume;
    logic skipDrop;
    logic giantDrop;
    logic deliver;
  } rxStrb_t;
endpackage

// File: rtl/rxlen_ctrl.sv
module rxlen_ctrl
  import rxlen_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int LEN_W = 16
) (
  input  logic [IDX_W-1:0] consIdx,
  input  logic [IDX_W-1:0] curIdx,
  input  logic             skipBusy,
  input  logic [HDR_W-1:0] bufHead,
  input  logic [LEN_W-1:0] cfgBufSize,
  input  logic [LEN_W-1:0] cfgRxOffset,
  output logic [LEN_W-1:0] hdrLen,
  output logic [LEN_W-1:0] usable,
  output rxStrb_t          strb
);
  logic avail;
  logic tooLong;

  always_comb begin
    // little-endian header: byte 0 is the low byte
    hdrLen  = LEN_W'({bufHead[15:8], bufHead[7:0]});
    usable  = cfgBufSize - cfgRxOffset;
    avail   = (consIdx != curIdx);
    tooLong = (hdrLen > usable);
    strb.consume   = avail;
    strb.skipDrop  = avail && skipBusy;
    strb.giantDrop = avail && !skipBusy && tooLong;
    strb.deliver   = avail && !skipBusy && !tooLong;
  end
endmodule

// File: rtl/rxlen_dp.sv
module rxlen_dp
  import rxlen_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrb_t          strb,
  input  logic [IDX_W-1:0] curIdx,
  input  logic [LEN_W-1:0] hdrLen,
  input  logic [LEN_W-1:0] usable,
  input  logic [LEN_W-1:0] cfgBufSize,
  input  logic [LEN_W-1:0] cfgRxOffset,
  output logic             skipBusy,
  output logic [IDX_W-1:0] consIdx,
  output logic             frmValid,
  output logic [IDX_W-1:0] frmIdx,
  output logic [LEN_W:0]   frmLen,
  output logic             relValid,
  output logic [IDX_W-1:0] relIdx,
  output logic [CNT_W-1:0] giantCount
);
  logic [LEN_W-1:0] skipCnt;

  assign skipBusy = (skipCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      consIdx    <= '0;
      skipCnt    <= '0;
      giantCount <= '0;
      frmValid   <= 1'b0;
      frmIdx     <= '0;
      frmLen     <= '0;
      relValid   <= 1'b0;
      relIdx     <= '0;
    end else begin
      frmValid <= strb.deliver;
      relValid <= strb.skipDrop || strb.giantDrop;
      if (strb.consume) begin
        consIdx <= consIdx + 1'b1;
      end
      if (strb.deliver) begin
        frmIdx <= consIdx;
        frmLen <= {1'b0, cfgRxOffset} + {1'b0, hdrLen};
      end
      if (strb.skipDrop || strb.giantDrop) begin
        relIdx <= consIdx;
      end
      if (strb.giantDrop) begin
        giantCount <= giantCount + 1'b1;
        skipCnt    <= hdrLen - usable;
      end else if (strb.skipDrop) begin
        skipCnt <= (skipCnt > cfgBufSize) ? (skipCnt - cfgBufSize) : '0;
      end
    end
  end

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (consIdx == curIdx) |=> $stable(consIdx));

  assert_frame_fits_R3: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |-> (frmLen <= {1'b0, cfgBufSize}));

  assert_giant_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    (giantCount != $past(giantCount)) |-> relValid);

  assert_skip_unparsed_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.consume && skipBusy) |=> (relValid && !frmValid && $stable(giantCount)));

  assert_skip_shrinks_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.skipDrop |=> (skipCnt < $past(skipCnt)));

  assert_exclusive_out_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(frmValid && relValid));
endmodule

// File: rtl/rxlen_filter.sv
module rxlen_filter
  import rxlen_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LEN_W = 16,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] cfgBufSize,
  input  logic [LEN_W-1:0] cfgRxOffset,
  input  logic [IDX_W-1:0] curIdx,
  input  logic [HDR_W-1:0] bufHead,
  output logic [IDX_W-1:0] consIdx,
  output logic             frmValid,
  output logic [IDX_W-1:0] frmIdx,
  output logic [LEN_W:0]   frmLen,
  output logic             relValid,
  output logic [IDX_W-1:0] relIdx,
  output logic [CNT_W-1:0] giantCount
);
  rxStrb_t          strb;
  logic             skipBusy;
  logic [LEN_W-1:0] hdrLen;
  logic [LEN_W-1:0] usable;

  rxlen_ctrl #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
    .consIdx(consIdx), .curIdx(curIdx), .skipBusy(skipBusy),
    .bufHead(bufHead), .cfgBufSize(cfgBufSize), .cfgRxOffset(cfgRxOffset),
    .hdrLen(hdrLen), .usable(usable), .strb(strb)
  );

  rxlen_dp #(.IDX_W(IDX_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .curIdx(curIdx),
    .hdrLen(hdrLen), .usable(usable), .cfgBufSize(cfgBufSize),
    .cfgRxOffset(cfgRxOffset), .skipBusy(skipBusy), .consIdx(consIdx),
    .frmValid(frmValid), .frmIdx(frmIdx), .frmLen(frmLen),
    .relValid(relValid), .relIdx(relIdx), .giantCount(giantCount)
  );
endmodule

// File: tb/sim_rxlen_filter.sv
module sim_rxlen_filter;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int IDX_W = 3;
  localparam int LEN_W = 16;
  localparam int CNT_W = 16;
  localparam int BUFSZ = 128;
  localparam int ROFS = 30;
  localparam int USABLE = BUFSZ - ROFS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LEN_W-1:0] cfgBufSize = LEN_W'(BUFSZ);
  logic [LEN_W-1:0] cfgRxOffset = LEN_W'(ROFS);
  logic [IDX_W-1:0] curIdx = '0;
  logic [15:0] bufHead;
  logic [IDX_W-1:0] consIdx, frmIdx, relIdx;
  logic frmValid, relValid;
  logic [LEN_W:0] frmLen;
  logic [CNT_W-1:0] giantCount;

  logic [15:0] hdrMem [DEPTH];
  assign bufHead = hdrMem[consIdx];

  rxlen_filter #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .cfgBufSize(cfgBufSize), .cfgRxOffset(cfgRxOffset),
    .curIdx(curIdx), .bufHead(bufHead), .consIdx(consIdx), .frmValid(frmValid),
    .frmIdx(frmIdx), .frmLen(frmLen), .relValid(relValid), .relIdx(relIdx),
    .giantCount(giantCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  bit    expRel[$];
  int    expIdx[$];
  int    expLen[$];
  int    expGiant[$];
  string expTag[$];

  int tbSkip = 0;
  int tbGiant = 0;
  int wrIdx = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: place a header in the ring, predict the outcome, optionally hand it to the block
  task automatic postBuf(int lo, int hi, bit advance);
    int len;
    len = lo + 256 * hi;
    hdrMem[wrIdx] = {8'(hi), 8'(lo)};
    if (tbSkip > 0) begin
      expRel.push_back(1); expLen.push_back(0); expTag.push_back("R5");
      tbSkip = (tbSkip > BUFSZ) ? tbSkip - BUFSZ : 0;
    end else if (len > USABLE) begin
      tbGiant++;
      tbSkip = len - USABLE;
      expRel.push_back(1); expLen.push_back(0); expTag.push_back("R4");
    end else begin
      expRel.push_back(0); expLen.push_back(ROFS + len); expTag.push_back("R3");
    end
    expIdx.push_back(wrIdx);
    expGiant.push_back(tbGiant);
    wrIdx = (wrIdx + 1) % DEPTH;
    if (advance) curIdx = IDX_W'(wrIdx);
    @(negedge clk);
  endtask

  task automatic drain();
    for (int k = 0; k < 40 && expRel.size() != 0; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: pop and compare at each negedge
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (frmValid && relValid) check(0, "R6", "both valids high", 1, 0);
      if (frmValid || relValid) begin
        if (expRel.size() == 0) begin
          check(0, "R6", "unexpected output", 1, 0);
        end else begin
          bit    eRel;
          int    eIdx, eLen, eGnt;
          string eTag;
          eRel = expRel.pop_front(); eIdx = expIdx.pop_front();
          eLen = expLen.pop_front(); eGnt = expGiant.pop_front();
          eTag = expTag.pop_front();
          check(relValid == eRel, eTag, "output kind relValid", int'(relValid), int'(eRel));
          if (eRel) begin
            check(int'(relIdx) == eIdx, eTag, "relIdx (R6 order)", int'(relIdx), eIdx);
          end else begin
            check(int'(frmIdx) == eIdx, eTag, "frmIdx", int'(frmIdx), eIdx);
            check(int'(frmLen) == eLen, eTag, "frmLen (R2 byte order)", int'(frmLen), eLen);
          end
          check(int'(giantCount) == eGnt, eTag, "giantCount", int'(giantCount), eGnt);
        end
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 50000);
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) hdrMem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7 reset state
    check(consIdx == 0, "R7", "consIdx after reset", int'(consIdx), 0);
    check(giantCount == 0, "R7", "giantCount after reset", int'(giantCount), 0);
    check(!frmValid && !relValid, "R7", "valids after reset", int'(frmValid | relValid), 0);

    // R3, R2: good frames, boundary at usable space, zero length, low-byte-first
    postBuf(8'h40, 8'h00, 1);
    postBuf(USABLE, 0, 1);
    postBuf(0, 0, 1);
    postBuf(8'h05, 8'h00, 1);
    drain();

    // R4, R5: one over -> single continuation, whose header would be a good frame
    postBuf(USABLE + 1, 0, 1);
    postBuf(8'h10, 0, 1);
    postBuf(8'h20, 0, 1);
    // R5: 261 bytes -> skip 163 -> two continuations
    postBuf(8'h05, 8'h01, 1);
    postBuf(8'h08, 0, 1);
    postBuf(8'h09, 0, 1);
    postBuf(8'h0a, 0, 1);
    drain();

    // R1: buffers present but engine index held -> nothing consumed
    begin
      int held;
      held = int'(consIdx);
      postBuf(8'h11, 0, 0);
      postBuf(8'h12, 0, 0);
      postBuf(8'hf0, 0, 0);
      repeat (4) begin
        check(!frmValid && !relValid, "R1", "output while held", int'(frmValid | relValid), 0);
        check(int'(consIdx) == held, "R1", "consIdx while held", int'(consIdx), held);
        @(negedge clk);
      end
      curIdx = IDX_W'(wrIdx);
      drain();
      check(int'(consIdx) == wrIdx, "R1", "consIdx after burst", int'(consIdx), wrIdx);
    end

    // R5: long giant, continuation run wraps the ring several times
    postBuf(8'h34, 8'h12, 1);
    for (int i = 0; i < 36; i++) postBuf(8'h01, 0, 1);
    postBuf(8'h21, 0, 1);
    drain();

    // R4, R5: a giant right where the previous skip ends is counted
    postBuf(USABLE + 1, 0, 1);
    postBuf(8'h02, 0, 1);
    postBuf(8'hc8, 0, 1);
    postBuf(8'h03, 0, 1);
    postBuf(8'h04, 0, 1);
    drain();

    check(expRel.size() == 0, "R6", "pending expected items", expRel.size(), 0);
    check(int'(giantCount) == tbGiant, "R4", "final giantCount", int'(giantCount), tbGiant);
    finishRun();
  end
endmodule